// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Master

This block moves one byte at a time over a two-wire synchronous link in which a single data wire carries traffic in both directions. The block always drives the serial clock. For a transmit it enables its data driver and shifts the byte out. For a receive it leaves the data wire undriven and samples it. The serial clock is the system clock divided by 12, 24, 48 or 96. Two control bits choose the level of the clock at rest and which clock edge samples the data. Between them they give four interface modes.

Software writes the byte to send, or any byte before a receive, through the data write strobe. A control write sets the rate, the clock level, the clock phase and the direction. The same write can launch a transfer through its go bit. When the eighth bit has been exchanged the block raises a completion flag. The flag stays up until software clears it. The received byte, or in transmit mode the bits seen on the wire, can then be read from the data output.

Top module: `hdx_sport`

## Requirements
- R1: After reset: sclk is 0, sdo_en is 0, busy is 0, done_flag is 0 and rd_data is 0. The reset mode is rate 0, clock rest level 0, phase 0, direction receive.
- R2: Control byte layout: bits [1:0] select the rate, bit 2 the rest level, bit 3 the phase, bit 4 the direction (1 = transmit) and bit 5 starts a transfer. One serial clock period lasts 12 << rate system clocks. A transfer keeps busy high for exactly 8 serial periods, which is 96 << rate cycles.
- R3: Whenever busy is low, sclk sits at the rest level written in control bit 2.
- R4: Every transfer makes exactly 16 sclk transitions. With phase 0, the data wire is sampled on each edge that leaves the rest level. With phase 1, it is sampled on each edge that returns to it.
- R5: In transmit mode, the byte is driven on sdo most significant bit first. sdo_en is high exactly while busy is high in transmit mode and is low at all other times.
- R6: In receive mode, sdi is captured at each sampling edge, most significant bit first. rd_data holds the received byte once busy falls.
- R7: In transmit mode, sdo holds its value for at least half a serial period (6 << rate cycles) before every sampling edge.
- R8: done_flag rises in the same cycle that busy falls. It stays high until flag_clr is asserted. When completion and flag_clr fall in the same cycle, the flag ends up set.
- R9: Data writes and control writes made while busy is high have no effect. They do not change the byte that is sent, the rate, the mode or the direction.
- R10: A data write in the same cycle as a starting control write loads the new byte, and that byte is the one transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control byte: rate, rest level, phase, direction, go |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | WIDTH | Byte to load into the shift register |
| flag_clr | input | 1 | Clears the completion flag |
| rd_data | output | WIDTH | Shift register contents |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Completion flag |
| sclk | output | 1 | Serial clock pin |
| sdo | output | 1 | Data pin output value |
| sdo_en | output | 1 | Data pin driver enable |
| sdi | input | 1 | Data pin input value |

## Verification
The completion event and a software clear of the flag can fall on the same clock edge. The bench provokes this by holding flag_clr high for a whole transfer. It then judges the flag twice: it must read 0 in the middle of the transfer, and it must read 1 right after the final edge, with the set winning. A data write can also coincide with a starting control write. The bench issues both in one cycle and expects the new byte, not the one loaded before, to appear on the wire. Across every rate, mode and direction, a model of the remote device counts sclk edges, captures the wire at the sampling edges and measures how long sdo holds before each of them.

// File: rtl/hdx_sport_pkg.sv
package hdx_sport_pkg;

    localparam int RATE_W  = 2;
    localparam int CTL_W   = 6;
    localparam int F_POL   = 2;
    localparam int F_PHA   = 3;
    localparam int F_DIR   = 4;
    localparam int F_GO    = 5;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              pol;
        logic              pha;
        logic              dir;
    } mode_t;

    function automatic mode_t decode_mode(input logic [CTL_W-1:0] w);
        mode_t m;
        m.rate = w[RATE_W-1:0];
        m.pol  = w[F_POL];
        m.pha  = w[F_PHA];
        m.dir  = w[F_DIR];
        return m;
    endfunction

endpackage

// File: rtl/hdx_sport_rate.sv
module hdx_sport_rate #(
    parameter int HALF_BASE = 6,
    parameter int RATE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int HALF_MAX = HALF_BASE << ((1 << RATE_W) - 1);
    localparam int CW       = $clog2(HALF_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        st_d   = st_q;
        lim_m1 = (CW'(HALF_BASE) << rate) - CW'(1);
        tick   = run && (st_q.cnt == lim_m1);
        if (!run || tick) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hdx_sport_shift.sv
module hdx_sport_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             sdi,
    output logic             busy,
    output logic             phase_odd,
    output logic [WIDTH-1:0] shreg,
    output logic             done
);
    localparam int PH_LAST = 2 * WIDTH - 1;
    localparam int PHW     = $clog2(2 * WIDTH);

    typedef struct packed {
        logic             busy;
        logic [PHW-1:0]   ph;
        logic [WIDTH-1:0] sr;
        logic             samp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (load)  st_d.sr = load_data;
            if (start) begin
                st_d.busy = 1'b1;
                st_d.ph   = '0;
            end
        end else if (tick) begin
            if (!st_q.ph[0]) st_d.samp = sdi;
            else             st_d.sr   = {st_q.sr[WIDTH-2:0], st_q.samp};
            if (st_q.ph == PHW'(PH_LAST)) begin
                st_d.busy = 1'b0;
                done      = 1'b1;
            end
            st_d.ph = st_q.ph + PHW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign phase_odd = st_q.ph[0];
    assign shreg     = st_q.sr;
endmodule

// File: rtl/hdx_sport.sv
module hdx_sport
    import hdx_sport_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int HALF_BASE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             dat_wr,
    input  logic [WIDTH-1:0] dat_wdata,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             done_flag,
    output logic             sclk,
    output logic             sdo,
    output logic             sdo_en,
    input  logic             sdi
);
    typedef struct packed {
        mode_t mode;
        logic  flag;
    } st_t;

    st_t  st_d, st_q;
    logic go, load, tick, done, phase_odd;

    always_comb begin
        st_d = st_q;
        go   = ctl_wr && !busy && ctl_wdata[F_GO];
        load = dat_wr && !busy;
        if (ctl_wr && !busy) st_d.mode = decode_mode(ctl_wdata);
        if (done)          st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hdx_sport_rate #(.HALF_BASE(HALF_BASE), .RATE_W(RATE_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .rate  (st_q.mode.rate),
        .tick  (tick)
    );

    hdx_sport_shift #(.WIDTH(WIDTH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (go),
        .load      (load),
        .load_data (dat_wdata),
        .sdi       (sdi),
        .busy      (busy),
        .phase_odd (phase_odd),
        .shreg     (rd_data),
        .done      (done)
    );

    assign done_flag = st_q.flag;
    assign sclk      = busy ? (st_q.mode.pol ^ st_q.mode.pha ^ phase_odd) : st_q.mode.pol;
    assign sdo       = rd_data[WIDTH-1];
    assign sdo_en    = busy && st_q.mode.dir;
endmodule

// File: rtl/hdx_sport_chk.sv
module hdx_sport_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done_flag,
    input logic flag_clr,
    input logic ctl_wr,
    input logic sclk,
    input logic sdo_en
);
    AST_FLAG_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);                                   // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);                      // R8
    AST_SCLK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(ctl_wr)) |-> $stable(sclk)); // R3
    AST_DRIVER_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdo_en);                                           // R5
    AST_DRIVER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sdo_en));                   // R9
    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(sclk)) |=> $stable(sclk));                  // R2
endmodule

bind hdx_sport hdx_sport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done_flag (done_flag),
    .flag_clr  (flag_clr),
    .ctl_wr    (ctl_wr),
    .sclk      (sclk),
    .sdo_en    (sdo_en)
);

// File: tb/hdx_sport_test.sv
`timescale 1ns/1ps
module hdx_sport_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       flag_clr = 1'b0;
    logic [7:0] rd_data;
    logic       busy, done_flag, sclk, sdo, sdo_en, sdi;
    logic       slv_bit = 1'b0;

    int total = 0;
    int bad   = 0;

    logic       cur_pol, cur_pha, cur_dir;
    logic       prev_sclk, prev_sdo;
    int         stable_cnt, edges, samp_k, busy_cnt, en_bad, su_bad, half;
    logic [7:0] cap, slv_byte;

    always #4 clk = ~clk;

    assign sdi = sdo_en ? sdo : slv_bit;

    hdx_sport uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .flag_clr(flag_clr),
        .rd_data(rd_data), .busy(busy), .done_flag(done_flag), .sclk(sclk),
        .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (busy) busy_cnt++;
        if (sdo_en !== (busy && cur_dir)) en_bad++;
        if (sdo !== prev_sdo) stable_cnt = 0;
        else                  stable_cnt++;
        if (sclk !== prev_sclk) begin
            edges++;
            if ((sclk != cur_pol) == (cur_pha == 1'b0)) begin
                if (cur_dir && stable_cnt < half) su_bad++;
                cap = {cap[6:0], sdi};
                samp_k++;
                if (samp_k < 8) slv_bit = slv_byte[7 - samp_k];
            end
        end
        prev_sclk = sclk;
        prev_sdo  = sdo;
    endtask

    task automatic xfer(input logic [1:0] rate, input bit pol, input bit pha, input bit dir,
                        input logic [7:0] tx, input logic [7:0] slv,
                        input bit hold_clr, input bit poke, input bit same);
        int cyc;
        logic [7:0] exp_b;
        half = 6 << rate;
        cur_pol = pol; cur_pha = pha; cur_dir = dir;
        ctl_wdata = {1'b0, dir, pha, pol, rate}; ctl_wr = 1'b1; step(); ctl_wr = 1'b0;
        if (!hold_clr) begin flag_clr = 1'b1; step(); flag_clr = 1'b0; end
        dat_wr = 1'b1; dat_wdata = same ? 8'h00 : tx; step(); dat_wr = 1'b0;
        step();
        prev_sclk = sclk; prev_sdo = sdo; stable_cnt = 1000;
        edges = 0; samp_k = 0; cap = '0; busy_cnt = 0; en_bad = 0; su_bad = 0;
        slv_byte = slv; slv_bit = slv[7];
        if (hold_clr) flag_clr = 1'b1;
        ctl_wdata = {1'b1, dir, pha, pol, rate}; ctl_wr = 1'b1;
        if (same) begin dat_wr = 1'b1; dat_wdata = tx; end
        step(); ctl_wr = 1'b0; dat_wr = 1'b0;
        cyc = 1;
        while (busy && cyc < 5000) begin
            if (poke && cyc == 3 * half) begin
                dat_wr = 1'b1; dat_wdata = ~tx;
                ctl_wr = 1'b1; ctl_wdata = {1'b1, ~dir, ~pha, ~pol, 2'b11};
            end
            step(); dat_wr = 1'b0; ctl_wr = 1'b0;
            if (hold_clr && cyc == half)
                check(done_flag == 1'b0, "R8 flag cleared mid transfer", done_flag, 0);
            cyc++;
        end
        exp_b = dir ? tx : slv;
        check(busy_cnt == 16 * half, "R2 busy length", busy_cnt, 16 * half);
        check(edges == 16, "R4 sclk transitions", edges, 16);
        check(done_flag == 1'b1, "R8 flag at completion", done_flag, 1);
        check(sclk == pol, "R3 rest level after transfer", sclk, pol);
        check(en_bad == 0, "R5 driver enable window", en_bad, 0);
        if (dir) begin
            check(cap == exp_b, "R5 transmitted byte on wire", cap, exp_b);
            check(su_bad == 0, "R7 setup before sampling edge", su_bad, 0);
        end
        check(rd_data == exp_b, dir ? "R5 loopback readback" : "R6 received byte", rd_data, exp_b);
        if (poke) check(cap == exp_b, "R9 writes while busy ignored", cap, exp_b);
        if (same) check(cap == exp_b, "R10 data with start", cap, exp_b);
        flag_clr = 1'b0;
        if (hold_clr) begin
            step();
            check(done_flag == 1'b1, "R8 set wins over clear", done_flag, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_pol = 0; cur_pha = 0; cur_dir = 0; half = 6;
        prev_sclk = 0; prev_sdo = 0; stable_cnt = 0; edges = 0; samp_k = 0;
        busy_cnt = 0; en_bad = 0; su_bad = 0; cap = '0; slv_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 1'b0,      "R1 sclk reset", sclk, 0);
        check(sdo_en == 1'b0,    "R1 sdo_en reset", sdo_en, 0);
        check(busy == 1'b0,      "R1 busy reset", busy, 0);
        check(done_flag == 1'b0, "R1 flag reset", done_flag, 0);
        check(rd_data == 8'h00,  "R1 data reset", rd_data, 0);

        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 4; m++)
                for (int d = 0; d < 2; d++)
                    xfer(2'(r), m[1], m[0], d[0], 8'(8'hA5 ^ (r * 16 + m * 2 + d) * 8'd7),
                         8'(8'h3C ^ (r * 29 + m * 5 + d * 3)), 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 16; i++)
            xfer(2'd0, i[1], i[0], i[2], 8'(i * 37 + 3), 8'(8'hFF - i * 17), 1'b0, 1'b0, 1'b0);

        xfer(2'd0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0);
        xfer(2'd1, 1'b1, 1'b1, 1'b1, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        xfer(2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h81, 1'b1, 1'b0, 1'b0);
        xfer(2'd2, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h00, 1'b1, 1'b0, 1'b0);
        xfer(2'd0, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b0);
        xfer(2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96, 1'b0, 1'b1, 1'b0);
        xfer(2'd0, 1'b0, 1'b1, 1'b1, 8'hE7, 8'h00, 1'b0, 1'b0, 1'b1);

        repeat (5) step();
        check(done_flag == 1'b1, "R8 flag held without clear", done_flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check(done_flag == 1'b0, "R8 flag cleared", done_flag, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule